// File: doc/BRIEF.md
# Serial Receive Queue with Programmable Trigger and Flow-Control Thresholds

This block is the receive half of a buffered asynchronous serial port. Bytes arrive one per cycle on a valid-qualified stream and are held in a 16-entry queue. Software drains the queue through a small register port. A control register sets two things: the fill level at which the "level reached" flag rises, and the fill level at which the block stops asking the sender for more bytes. A line-status register records a lost byte. Reading it clears it.

Two flags are presented both on pins and in a status register. The level flag rises when the queue holds at least the trigger count. Below that level, the data-available flag shows that the queue is not empty. Both flags are refreshed only when a byte enters or leaves the queue. The accept output is a registered flow-control hint for the upstream receiver, which may still push bytes while it is low.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0060, the line-status register reads 0x0000, both flags are 0 and `in_ready` is 1.
- R2: Every byte presented with `in_valid` while the queue holds fewer than 16 bytes is stored. Reads of the data register (address 3) return the stored bytes in arrival order, each read removing one byte.
- R3: A byte presented while the queue holds 16 bytes, with no pop in the same cycle, is discarded without disturbing the stored bytes, and bit 0 of the line-status register is set.
- R4: A read of the line-status register (address 2) returns its value and clears all of its bits. A write loads it with `reg_wdata`. An overrun in the same cycle sets bit 0 after the clear or load.
- R5: Control bits 8:7 choose a trigger count of 1, 4, 8 or 14 for codes 0 to 3. When the fill is at or above the trigger count, the level flag is 1 and the data-available flag is 0. Otherwise the level flag is 0 and data-available equals (fill > 0). The status register (address 1) shows the level flag in bit 1, data-available in bit 0, and reads 1 in bits 6:5.
- R6: The flags are recomputed only in a cycle where a byte is stored or removed, using the control value held before that cycle. Writing the control register alone leaves them unchanged.
- R7: Control bits 11:9 index the accept limit list 15, 1, 4, 6, 8, 10, 12, 14 (codes 0 to 7). After each clock edge, `in_ready` is 1 exactly when the new fill is below the limit selected by the new control value.
- R8: A data-register read with an empty queue returns 0 and leaves the fill and the stored order unchanged.
- R9: A pop and a push in the same cycle are applied pop first. With a full queue, both take effect, the fill stays 16, and no overrun is flagged.
- R10: `reg_rdata` carries the result of a read from the cycle after `reg_rd`. The control register (address 0) reads back the last value written to it.
- R11: Read and write positions wrap around the 16 entries, so a stream far longer than 16 bytes keeps its order under simultaneous fill and drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte present this cycle |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Flow-control hint: fill below accept limit |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 status, 2 line status, 3 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after the strobe |
| rxf_level_hit | output | 1 | Fill at or above trigger count |
| rxf_data_avail | output | 1 | Non-empty but below trigger count |

## Verification
The bench runs every trigger code and every accept-limit code up to full fill. A wrong table entry would move the flag edge or the `in_ready` drop by one or more bytes. It forces overruns and then reads the line-status register twice. A design that failed to clear on read, or that let a discarded byte overwrite the oldest entry, would show a stale bit or a corrupted byte order. It also covers pop-with-push at full and empty data reads, which expose a fill counter that drifts or flags a false overrun. It covers control writes with no traffic, which catch flags that update too eagerly. A long mixed run checks wrap-around of the indices against a queue model.

// File: rtl/rx_trig_fifo_pkg.sv
package rx_trig_fifo_pkg;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_LINE = 2'd2,
    RA_DATA = 2'd3
  } reg_addr_e;

  // control field positions (software-visible)
  localparam int TRIG_LSB = 7;
  localparam int TRIG_W   = 2;
  localparam int LIM_LSB  = 9;
  localparam int LIM_W    = 3;

  // status register layout
  localparam int STAT_DR_BIT  = 0;
  localparam int STAT_RDF_BIT = 1;
  localparam logic [15:0] STAT_CONST = 16'h0060;

  // line-status overrun position
  localparam int LINE_OVR_BIT = 0;

  function automatic logic [7:0] trig_level(input logic [TRIG_W-1:0] code);
    case (code)
      2'd0:    trig_level = 8'd1;
      2'd1:    trig_level = 8'd4;
      2'd2:    trig_level = 8'd8;
      default: trig_level = 8'd14;
    endcase
  endfunction

  function automatic logic [7:0] accept_limit(input logic [LIM_W-1:0] code);
    // code 0 is the odd one out; the rest step by two from 4
    case (code)
      3'd0:    accept_limit = 8'd15;
      3'd1:    accept_limit = 8'd1;
      default: accept_limit = 8'({code, 1'b0});
    endcase
  endfunction

endpackage

// File: rtl/rx_trig_fifo_mem.sv
module rx_trig_fifo_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  // read-first: a same-address write in the same cycle returns the old byte
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/rx_trig_fifo_ptrs.sv
module rx_trig_fifo_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          overrun,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [LW-1:0] fill,
  output logic [LW-1:0] fill_next
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic empty, full;

  assign empty   = (fill == '0);
  assign full    = (fill == FULL);
  assign pop_ok  = pop_req && !empty;
  // pop is applied first, so a full queue still takes a byte when drained
  assign push_ok = push_req && (!full || pop_ok);
  assign overrun = push_req && !push_ok;

  always_comb begin
    fill_next = fill;
    case ({push_ok, pop_ok})
      2'b10:   fill_next = fill + LW'(1);
      2'b01:   fill_next = fill - LW'(1);
      default: fill_next = fill;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      fill   <= '0;
    end else begin
      fill <= fill_next;
      if (push_ok) wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + AW'(1);
      if (pop_ok)  rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + AW'(1);
    end
  end

endmodule

// File: rtl/rx_trig_fifo_flags.sv
module rx_trig_fifo_flags
  import rx_trig_fifo_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [TRIG_W-1:0] trig_code,
  input  logic [LIM_W-1:0]  lim_code,
  input  logic [LW-1:0]     fill_new,
  output logic              level_hit,
  output logic              data_avail,
  output logic              accept
);

  logic [LW-1:0] trig_cnt, lim_cnt;
  logic          at_trig;

  assign trig_cnt = LW'(trig_level(trig_code));
  assign lim_cnt  = LW'(accept_limit(lim_code));
  assign at_trig  = (fill_new >= trig_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_hit  <= 1'b0;
      data_avail <= 1'b0;
      accept     <= 1'b1;
    end else begin
      accept <= (fill_new < lim_cnt);
      if (upd) begin
        level_hit  <= at_trig;
        data_avail <= !at_trig && (fill_new != '0);
      end
    end
  end

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
  import rx_trig_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          rxf_level_hit,
  output logic          rxf_data_avail
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [RW-1:0] ctrl_q, ctrl_next;
  logic [RW-1:0] line_q, line_next;
  logic [RW-1:0] hold_q;
  logic          data_sel_q;

  logic          push_ok, pop_ok, ovr_ev;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [LW-1:0] fill_q, fill_next;
  logic [DW-1:0] mem_rdata;

  logic rd_ctrl, rd_stat, rd_line, rd_data;
  logic wr_ctrl, wr_line;

  assign rd_ctrl = reg_rd && (reg_addr == RA_CTRL);
  assign rd_stat = reg_rd && (reg_addr == RA_STAT);
  assign rd_line = reg_rd && (reg_addr == RA_LINE);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_line = reg_wr && (reg_addr == RA_LINE);

  rx_trig_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) ptrs_i (
    .clk      (clk),
    .rst      (rst),
    .push_req (in_valid),
    .pop_req  (rd_data),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .overrun  (ovr_ev),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .fill     (fill_q),
    .fill_next(fill_next)
  );

  rx_trig_fifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wr_idx),
    .wdata(in_data),
    .re   (pop_ok),
    .raddr(rd_idx),
    .rdata(mem_rdata)
  );

  assign ctrl_next = wr_ctrl ? reg_wdata : ctrl_q;

  rx_trig_fifo_flags #(.LW(LW)) flags_i (
    .clk       (clk),
    .rst       (rst),
    .upd       (push_ok || pop_ok),
    .trig_code (ctrl_q[TRIG_LSB +: TRIG_W]),
    .lim_code  (ctrl_next[LIM_LSB +: LIM_W]),
    .fill_new  (fill_next),
    .level_hit (rxf_level_hit),
    .data_avail(rxf_data_avail),
    .accept    (in_ready)
  );

  // line status: clear on read, load on write, overrun sets last
  always_comb begin
    line_next = line_q;
    if (rd_line) line_next = '0;
    if (wr_line) line_next = reg_wdata;
    if (ovr_ev)  line_next[LINE_OVR_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      line_q     <= '0;
      hold_q     <= '0;
      data_sel_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_next;
      line_q <= line_next;
      if (reg_rd) begin
        data_sel_q <= pop_ok;
        if (rd_ctrl) hold_q <= ctrl_q;
        else if (rd_stat) begin
          hold_q <= RW'(STAT_CONST);
          hold_q[STAT_RDF_BIT] <= rxf_level_hit;
          hold_q[STAT_DR_BIT]  <= rxf_data_avail;
        end
        else if (rd_line) hold_q <= line_q;
        else hold_q <= '0;
      end
    end
  end

  assign reg_rdata = data_sel_q ? RW'(mem_rdata) : hold_q;

endmodule

// File: rtl/rx_trig_fifo_chk.sv
module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter int RW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          level_hit,
  input logic          data_avail,
  input logic [LW-1:0] fill,
  input logic          push_ok,
  input logic          pop_ok,
  input logic [RW-1:0] line_q
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    push_ok && !pop_ok |=> fill == $past(fill) + ONE); // R2

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    in_valid && !push_ok |=> line_q[0]); // R3

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == 2'd2 && !reg_wr && !(in_valid && fill == FULL)
    |=> line_q == '0); // R4

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(level_hit && data_avail)); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !push_ok && !pop_ok |=> $stable(level_hit) && $stable(data_avail)); // R6

  AST_READY_ROOM: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> fill < FULL); // R7

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == 2'd3 && fill == '0 && !in_valid |=> fill == '0); // R8

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
    in_valid && reg_rd && reg_addr == 2'd3 && fill == FULL && !reg_wr
    |=> fill == FULL && $stable(line_q)); // R9

endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .LW(LW), .RW(RW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .level_hit (rxf_level_hit),
  .data_avail(rxf_data_avail),
  .fill      (fill_q),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .line_q    (line_q)
);

// File: tb/rx_trig_fifo_tb_top.sv
module rx_trig_fifo_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        rxf_level_hit, rxf_data_avail;

  always #5 clk = ~clk;

  rx_trig_fifo dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxf_level_hit(rxf_level_hit), .rxf_data_avail(rxf_data_avail)
  );

  // behavioural reference
  byte unsigned m_q[$];
  logic [15:0]  m_ctrl, m_line;
  logic         m_rdf, m_dr, m_rdy;
  logic [15:0]  m_rdata;
  int           n_chk = 0, n_fail = 0;
  string        phase = "R1";
  byte unsigned seq = 8'h10;

  function automatic int trig_of(logic [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic int lim_of(logic [2:0] c);
    int t[8] = '{15, 1, 4, 6, 8, 10, 12, 14};
    return t[c];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s): actual %h expected %h at %0t",
               req, phase, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one clock: inputs already driven; update model, step, compare
  task automatic cyc(bit v, byte unsigned d, bit rd, bit wr,
                     logic [1:0] a, logic [15:0] wd);
    bit popped = 0, pushed = 0, ovr = 0;
    logic [15:0] st;
    in_valid = v; in_data = d; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd;
    if (rd) begin
      st = 16'h0060; st[1] = m_rdf; st[0] = m_dr;
      case (a)
        2'd0: m_rdata = m_ctrl;
        2'd1: m_rdata = st;
        2'd2: m_rdata = m_line;
        default: m_rdata = (m_q.size() > 0) ? 16'(m_q[0]) : 16'h0000;
      endcase
      if (a == 2'd3 && m_q.size() > 0) begin
        void'(m_q.pop_front());
        popped = 1;
      end
    end
    if (v) begin
      if (m_q.size() < 16) begin m_q.push_back(d); pushed = 1; end
      else ovr = 1;
    end
    if (pushed || popped) begin
      m_rdf = (m_q.size() >= trig_of(m_ctrl[8:7]));
      m_dr  = !m_rdf && (m_q.size() > 0);
    end
    if (rd && a == 2'd2) m_line = '0;
    if (wr && a == 2'd2) m_line = wd;
    if (ovr) m_line[0] = 1'b1;
    if (wr && a == 2'd0) m_ctrl = wd;
    m_rdy = (m_q.size() < lim_of(m_ctrl[11:9]));
    @(posedge clk);
    @(negedge clk);
    chk("R7 in_ready", 16'(in_ready), 16'(m_rdy));
    chk("R5 level_hit", 16'(rxf_level_hit), 16'(m_rdf));
    chk("R5 data_avail", 16'(rxf_data_avail), 16'(m_dr));
    if (rd) begin
      case (a)
        2'd0: chk("R10 ctrl read", reg_rdata, m_rdata);
        2'd1: chk("R5 status read", reg_rdata, m_rdata);
        2'd2: chk("R4 line read", reg_rdata, m_rdata);
        default: chk("R2 data read", reg_rdata, m_rdata);
      endcase
    end
    in_valid = 0; reg_rd = 0; reg_wr = 0;
  endtask

  task automatic push1();  cyc(1, seq, 0, 0, 2'd0, 16'h0); seq++; endtask
  task automatic pop1();   cyc(0, 8'h0, 1, 0, 2'd3, 16'h0); endtask
  task automatic rdreg(logic [1:0] a); cyc(0, 8'h0, 1, 0, a, 16'h0); endtask
  task automatic wrreg(logic [1:0] a, logic [15:0] v); cyc(0, 8'h0, 0, 1, a, v); endtask
  task automatic drain(); while (m_q.size() > 0) pop1(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_up();
  end

  initial begin
    m_q.delete(); m_ctrl = '0; m_line = '0; m_rdf = 0; m_dr = 0; m_rdy = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    phase = "R1";
    chk("R1 in_ready", 16'(in_ready), 16'h1);
    chk("R1 flags", {14'h0, rxf_level_hit, rxf_data_avail}, 16'h0);
    rdreg(2'd0); rdreg(2'd1); rdreg(2'd2);
    chk("R1 status value", reg_rdata, 16'h0000); // last read was line status
    rdreg(2'd1);
    chk("R1 status reset", reg_rdata, 16'h0060);

    phase = "R2";
    wrreg(2'd0, 16'h0100); // trigger code 2 (8)
    for (int i = 0; i < 5; i++) push1();
    drain();

    phase = "R5";
    for (int c = 0; c < 4; c++) begin
      wrreg(2'd0, 16'(c << 7));
      for (int i = 0; i < 15; i++) begin push1(); rdreg(2'd1); end
      drain();
      rdreg(2'd1);
    end

    phase = "R3";
    wrreg(2'd0, 16'h0000);
    for (int i = 0; i < 18; i++) push1();
    rdreg(2'd2);
    chk("R3 overrun bit", reg_rdata, 16'h0001);
    phase = "R4";
    rdreg(2'd2);
    chk("R4 cleared on read", reg_rdata, 16'h0000);
    wrreg(2'd2, 16'hABCD); rdreg(2'd2);
    wrreg(2'd2, 16'h1230); cyc(1, seq, 0, 1, 2'd2, 16'h4560); seq++; rdreg(2'd2);
    drain();

    phase = "R6";
    wrreg(2'd0, 16'h0100);
    for (int i = 0; i < 5; i++) push1();
    wrreg(2'd0, 16'h0000); // trigger 1 would set level_hit, must not yet
    chk("R6 no refresh", {14'h0, rxf_level_hit, rxf_data_avail}, 16'h0001);
    push1();
    chk("R6 refresh on push", {14'h0, rxf_level_hit, rxf_data_avail}, 16'h0002);
    drain();

    phase = "R7";
    for (int c = 0; c < 8; c++) begin
      wrreg(2'd0, 16'(c << 9));
      for (int i = 0; i < 16; i++) push1();
      drain();
    end

    phase = "R8";
    wrreg(2'd0, 16'h0000);
    pop1();
    chk("R8 empty read", reg_rdata, 16'h0000);
    push1(); pop1(); pop1();

    phase = "R9";
    for (int i = 0; i < 16; i++) push1();
    cyc(1, seq, 1, 0, 2'd3, 16'h0); seq++;
    cyc(1, seq, 1, 0, 2'd3, 16'h0); seq++;
    rdreg(2'd2);
    chk("R9 no overrun", reg_rdata, 16'h0000);
    drain();

    phase = "R11";
    push1(); push1(); push1();
    for (int i = 0; i < 40; i++) begin cyc(1, seq, 1, 0, 2'd3, 16'h0); seq++; end
    drain();
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 5) push1();
      else if (r < 8) pop1();
      else if (r == 8) begin cyc(1, seq, 1, 0, 2'd3, 16'h0); seq++; end
      else wrreg(2'd0, 16'($urandom_range(0, 15) << 7));
    end
    drain();
    rdreg(2'd2);

    finish_up();
  end

endmodule